// File: doc/BRIEF.md
# Lockstep Accumulator Lane Array

This block is a row of eight identical processing lanes that all execute one broadcast instruction per cycle. Each lane owns a 16-bit signed accumulator and a private bank of sixteen 16-bit words. Lane k only ever touches column k of a row, so one row address names a full vector spread across the banks. The supported operations are:

- moving data between accumulators and their banks,
- two's-complement arithmetic against the bank,
- a signed compare,
- clearing,
- loading an immediate constant,
- copying one lane's accumulator into the others.

A sequencing unit outside the block supplies each decoded instruction. The instruction carries an opcode, a row number (which that unit may take from one of its own index registers), a source-lane number for the copy, an immediate, and a per-lane enable mask. The mask lets one instruction stream emulate a conditional. Lanes whose mask bit is 0 sit out the instruction: their accumulator and their bank stay as they are. Compare instructions report one result bit per lane, whatever the mask. The sequencing unit can later narrow the mask from those bits. A one-cycle completion pulse follows every accepted instruction.

Top module: `simd_array`

## Requirements
- R1: Synchronous active-high reset clears every accumulator, every bank word and the compare vector, and holds the completion pulse low.
- R2: Opcode 1 (load) sets accumulator k to bank word (row, k) in every enabled lane.
- R3: Opcode 2 (store) writes accumulator k into bank word (row, k) in every enabled lane.
- R4: Opcodes 3, 4 and 5 replace accumulator k with acc+mem, acc−mem or acc×mem respectively, where mem is bank word (row, k). The result keeps only the low 16 bits, wrapping on overflow.
- R5: A lane whose mask bit is 0 keeps its accumulator and all its bank words unchanged, whatever the opcode.
- R6: Opcode 6 sets compare bit k to 1 when accumulator k is less than bank word (row, k) as signed numbers, else 0. Opcode 7 does the same for equality. All lanes report, independent of the mask, and no accumulator changes.
- R7: The compare vector keeps its value through every instruction other than opcodes 6 and 7, and through idle cycles.
- R8: Opcode 8 (copy) loads every enabled lane's accumulator with the accumulator value that lane `in_sel` held before the instruction.
- R9: Opcode 10 (clear) zeroes the accumulator of every enabled lane.
- R10: Opcode 9 loads the immediate `in_imm` into every enabled lane's accumulator.
- R11: The completion pulse is high for exactly the cycle after each cycle with `in_valid` high. A cycle with `in_valid` low changes no accumulator, bank word or compare bit.
- R12: Results appear one clock after the instruction is presented. Accumulator k is visible on `acc_flat[16k+15:16k]`, and compare bit k is `cmp_bits[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode |
| in_row | input | 4 | Bank row for load, store, arithmetic and compare |
| in_sel | input | 3 | Source lane for the copy |
| in_imm | input | 16 | Immediate for opcode 9 |
| in_mask | input | 8 | Per-lane enable, bit k for lane k |
| acc_flat | output | 128 | All accumulators, lane k at bits 16k+15:16k |
| cmp_bits | output | 8 | Latest compare result, bit k for lane k |
| done | output | 1 | One-cycle pulse after each accepted instruction |

## Verification
The properties assume that `in_op` holds one of the defined opcodes whenever `in_valid` is high. They also assume that `in_sel` names an existing lane and that instruction inputs are stable around the rising edge. The stimulus only drives values from the opcode set and lane numbers below eight. It changes inputs at the falling edge and drops `in_valid` between instructions, so every instruction is checked in isolation against the state it left behind.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int LANES     = 8;
    localparam int DATA_W    = 16;
    localparam int BANK_ROWS = 16;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_MUL   = 4'd5,
        OP_CLT   = 4'd6,
        OP_CEQ   = 4'd7,
        OP_COPY  = 4'd8,
        OP_IMM   = 4'd9,
        OP_CLR   = 4'd10
    } op_e;

    // Opcode classes shared by the lanes and the result register
    function automatic logic op_writes_acc(op_e op);
        case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_MUL,
            OP_COPY, OP_IMM, OP_CLR: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_compare(op_e op);
        return (op == OP_CLT) || (op == OP_CEQ);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int ROWS = BANK_ROWS,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  op_e           op,
    input  logic [RW-1:0] row,
    input  logic [W-1:0]  imm,
    input  logic [W-1:0]  copy_val,
    output logic [W-1:0]  acc_q,
    output logic          lt_o,
    output logic          eq_o
);

    logic [W-1:0] bank [ROWS];
    logic [W-1:0] rd_val;
    logic [W-1:0] acc_d;

    assign rd_val = bank[row];

    always_comb begin
        case (op)
            OP_LOAD: acc_d = rd_val;
            OP_ADD:  acc_d = acc_q + rd_val;
            OP_SUB:  acc_d = acc_q - rd_val;
            OP_MUL:  acc_d = acc_q * rd_val;
            OP_COPY: acc_d = copy_val;
            OP_IMM:  acc_d = imm;
            OP_CLR:  acc_d = acc_q - acc_q;
            default: acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (fire && op_writes_acc(op)) begin
            acc_q <= acc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) begin
                bank[i] <= '0;
            end
        end else if (fire && op == OP_STORE) begin
            bank[row] <= acc_q;
        end
    end

    // Compare flags are produced for every lane; the mask plays no part
    assign lt_o = $signed(acc_q) < $signed(rd_val);
    assign eq_o = (acc_q == rd_val);

endmodule

// File: rtl/simd_copy_sel.sv
module simd_copy_sel #(
    parameter int N   = 8,
    parameter int W   = 16,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] acc_flat,
    input  logic [SW-1:0]  sel,
    output logic [W-1:0]   val
);

    // AND-OR selection across lanes
    logic [W-1:0] pick [N];

    for (genvar g = 0; g < N; g++) begin : g_pick
        assign pick[g] = (sel == SW'(g)) ? acc_flat[g*W +: W] : '0;
    end

    always_comb begin
        val = '0;
        for (int i = 0; i < N; i++) begin
            val = val | pick[i];
        end
    end

endmodule

// File: rtl/simd_result_reg.sv
module simd_result_reg
    import simd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  op_e          op,
    input  logic [N-1:0] lt_vec,
    input  logic [N-1:0] eq_vec,
    output logic [N-1:0] cmp_q,
    output logic         done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= valid;
            if (valid && op_is_compare(op)) begin
                cmp_q <= (op == OP_CLT) ? lt_vec : eq_vec;
            end
        end
    end

endmodule

// File: rtl/simd_array.sv
module simd_array
    import simd_pkg::*;
#(
    parameter int N     = LANES,
    parameter int W     = DATA_W,
    parameter int DEPTH = BANK_ROWS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [3:0]               in_op,
    input  logic [$clog2(DEPTH)-1:0] in_row,
    input  logic [$clog2(N)-1:0]     in_sel,
    input  logic [W-1:0]             in_imm,
    input  logic [N-1:0]             in_mask,
    output logic [N*W-1:0]           acc_flat,
    output logic [N-1:0]             cmp_bits,
    output logic                     done
);

    op_e          op;
    logic [W-1:0] copy_val;
    logic [N-1:0] lt_vec;
    logic [N-1:0] eq_vec;

    assign op = op_e'(in_op);

    simd_copy_sel #(.N(N), .W(W)) u_copy (
        .acc_flat (acc_flat),
        .sel      (in_sel),
        .val      (copy_val)
    );

    for (genvar k = 0; k < N; k++) begin : g_lane
        simd_lane #(.W(W), .ROWS(DEPTH)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .fire     (in_valid & in_mask[k]),
            .op       (op),
            .row      (in_row),
            .imm      (in_imm),
            .copy_val (copy_val),
            .acc_q    (acc_flat[k*W +: W]),
            .lt_o     (lt_vec[k]),
            .eq_o     (eq_vec[k])
        );
    end

    simd_result_reg #(.N(N)) u_result (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .op     (op),
        .lt_vec (lt_vec),
        .eq_vec (eq_vec),
        .cmp_q  (cmp_bits),
        .done_q (done)
    );

endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk
    import simd_pkg::*;
#(
    parameter int N = LANES,
    parameter int W = DATA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [3:0]           in_op,
    input logic [$clog2(N)-1:0] in_sel,
    input logic [W-1:0]         in_imm,
    input logic [N-1:0]         in_mask,
    input logic [N*W-1:0]       acc_flat,
    input logic [N-1:0]         cmp_bits,
    input logic                 done
);

    // R11: completion pulse tracks the accepted instruction
    a_r11_done_high: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);
    a_r11_done_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);
    a_r11_idle_acc: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_flat));

    // R7: compare vector only moves on compare opcodes
    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || !(in_op == OP_CLT || in_op == OP_CEQ)) |=> $stable(cmp_bits));

    for (genvar k = 0; k < N; k++) begin : g_lane_chk
        // R5: disabled lane keeps its accumulator
        a_r5_masked_hold: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mask[k]) |=> $stable(acc_flat[k*W +: W]));
        // R6: compares leave the accumulator alone
        a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (in_op == OP_CLT || in_op == OP_CEQ)) |=> $stable(acc_flat[k*W +: W]));
        // R8: copy from the selected lane
        a_r8_copy: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == OP_COPY && in_mask[k])
            |=> acc_flat[k*W +: W] == $past(acc_flat[in_sel*W +: W]));
        // R9: clear
        a_r9_clear: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == OP_CLR && in_mask[k]) |=> acc_flat[k*W +: W] == '0);
        // R10: immediate load
        a_r10_imm: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == OP_IMM && in_mask[k]) |=> acc_flat[k*W +: W] == $past(in_imm));
    end

endmodule

bind simd_array simd_array_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/simd_array_test.sv
`timescale 1ns/1ps
module simd_array_test;
    import simd_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = 4'd0;
    logic [3:0]   in_row = 4'd0;
    logic [2:0]   in_sel = 3'd0;
    logic [15:0]  in_imm = 16'd0;
    logic [7:0]   in_mask = 8'd0;
    logic [127:0] acc_flat;
    logic [7:0]   cmp_bits;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    simd_array uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_row(in_row), .in_sel(in_sel), .in_imm(in_imm), .in_mask(in_mask),
        .acc_flat(acc_flat), .cmp_bits(cmp_bits), .done(done)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  row;
        logic [2:0]  sel;
        logic [15:0] imm;
        logic [7:0]  mask;
        logic [2:0]  lane;
        logic [15:0] exp_acc;
        logic [7:0]  exp_cmp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{OP_IMM,   4'd0, 3'd0, 16'h0005, 8'hFF, 3'd3, 16'h0005, 8'h00, 4'd10}, // R10 all lanes 5
        '{OP_STORE, 4'd2, 3'd0, 16'h0000, 8'hFF, 3'd0, 16'h0005, 8'h00, 4'd3},  // R3 row2 = 5
        '{OP_IMM,   4'd0, 3'd0, 16'hFFFD, 8'h0F, 3'd6, 16'h0005, 8'h00, 4'd5},  // R5 lane6 untouched
        '{OP_STORE, 4'd3, 3'd0, 16'h0000, 8'hF0, 3'd1, 16'hFFFD, 8'h00, 4'd3},  // R3 row3 upper lanes
        '{OP_CLT,   4'd2, 3'd0, 16'h0000, 8'h00, 3'd2, 16'hFFFD, 8'h0F, 4'd6},  // R6 signed less, mask 0
        '{OP_CEQ,   4'd3, 3'd0, 16'h0000, 8'h01, 3'd4, 16'h0005, 8'hF0, 4'd6},  // R6 equality
        '{OP_ADD,   4'd2, 3'd0, 16'h0000, 8'hFF, 3'd0, 16'h0002, 8'hF0, 4'd4},  // R4 add, R7 hold
        '{OP_MUL,   4'd2, 3'd0, 16'h0000, 8'h80, 3'd7, 16'h0032, 8'hF0, 4'd4},  // R4 mul
        '{OP_SUB,   4'd3, 3'd0, 16'h0000, 8'h30, 3'd5, 16'h0005, 8'hF0, 4'd4},  // R4 sub
        '{OP_COPY,  4'd0, 3'd7, 16'h0000, 8'h0E, 3'd2, 16'h0032, 8'hF0, 4'd8},  // R8 copy lane7
        '{OP_LOAD,  4'd3, 3'd0, 16'h0000, 8'h01, 3'd0, 16'h0000, 8'hF0, 4'd2},  // R2, R5 bank kept 0
        '{OP_CLR,   4'd0, 3'd0, 16'h0000, 8'hC0, 3'd6, 16'h0000, 8'hF0, 4'd9},  // R9 clear
        '{OP_IMM,   4'd0, 3'd0, 16'h7FFF, 8'hFF, 3'd4, 16'h7FFF, 8'hF0, 4'd10}, // R10
        '{OP_ADD,   4'd2, 3'd0, 16'h0000, 8'hFF, 3'd4, 16'h8004, 8'hF0, 4'd4},  // R4 wrap
        '{OP_IMM,   4'd0, 3'd0, 16'h0100, 8'hFF, 3'd1, 16'h0100, 8'hF0, 4'd10}, // R10
        '{OP_STORE, 4'd5, 3'd0, 16'h0000, 8'hFF, 3'd1, 16'h0100, 8'hF0, 4'd3},  // R3
        '{OP_MUL,   4'd5, 3'd0, 16'h0000, 8'hFF, 3'd1, 16'h0000, 8'hF0, 4'd4},  // R4 low 16 bits
        '{OP_LOAD,  4'd2, 3'd0, 16'h0000, 8'hFF, 3'd7, 16'h0005, 8'hF0, 4'd2}   // R2 row2 reload
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_of(input logic [127:0] v, input int k);
        return v[k*16 +: 16];
    endfunction

    // Present one instruction, sample one cycle later, then go idle
    task automatic issue(input logic [3:0] op, input logic [3:0] row, input logic [2:0] sel,
                         input logic [15:0] imm, input logic [7:0] mask);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_row = row; in_sel = sel; in_imm = imm; in_mask = mask;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 acc", acc_flat, 128'd0);
        check("R1 cmp", {120'd0, cmp_bits}, 128'd0);
        check("R1 done", {127'd0, done}, 128'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].row, TBL[i].sel, TBL[i].imm, TBL[i].mask);
            check($sformatf("R%0d acc step %0d", TBL[i].req, i),
                  {112'd0, lane_of(acc_flat, int'(TBL[i].lane))}, {112'd0, TBL[i].exp_acc});
            check($sformatf("R%0d cmp step %0d", TBL[i].req, i), {120'd0, cmp_bits}, {120'd0, TBL[i].exp_cmp});
            check($sformatf("R12 done step %0d", i), {127'd0, done}, 128'd1);
        end

        // R11: idle cycle with an instruction pattern but valid low
        @(negedge clk);
        in_op = OP_IMM; in_imm = 16'h1234; in_mask = 8'hFF; in_row = 4'd0;
        @(negedge clk);
        check("R11 idle acc lane7", {112'd0, lane_of(acc_flat, 7)}, 128'h5);
        check("R11 done low", {127'd0, done}, 128'd0);
        check("R7 cmp idle", {120'd0, cmp_bits}, 128'hF0);

        // R6: compare covers all lanes with mask 0, row2 all 5
        issue(OP_CEQ, 4'd2, 3'd0, 16'd0, 8'h00);
        check("R6 ceq all", {120'd0, cmp_bits}, 128'hFF);

        // R1: mid-run reset clears banks too
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 acc after reset", acc_flat, 128'd0);
        check("R1 cmp after reset", {120'd0, cmp_bits}, 128'd0);
        issue(OP_IMM, 4'd0, 3'd0, 16'h00AA, 8'hFF);
        issue(OP_LOAD, 4'd2, 3'd0, 16'd0, 8'hFF);
        check("R1 bank cleared", {112'd0, lane_of(acc_flat, 3)}, 128'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule